// File: doc/BRIEF.md
# Shortest-First Transfer Dispatcher with Direction Switching

This block holds up to eight pending transfer requests for a network device and decides which one is served next. Each request has a direction (read, towards the receive datapath, or write, towards the transmit datapath), a start time and a size. The block always picks the pending request with the smallest size. Requests enter on a valid/ready push port. The chosen request leaves on a valid/ready grant port. A completion pulse frees the request's slot once its service has finished.

The device has separate receive and transmit datapaths, and only one of them is enabled at a time. If the chosen request runs in a different direction from the last request served, the dispatcher first runs a request/acknowledge switch exchange. The grant is offered only after that exchange has finished. A `working` level tells a separate rate governor whether the device has any work held.

Back-pressure rules. A push is taken on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` depends only on how many slots are occupied, never on `push_valid`. Once `grant_valid` rises, it stays high with stable fields until the edge where `grant_ready` is high.

Top module: `sjf_dispatch`

## Requirements
- R1: `push_ready` is low exactly when all 8 slots are occupied. A push is stored only on an edge where `push_valid` and `push_ready` are both high. A refused push changes nothing.
- R2: When the dispatcher is idle and any slot is occupied, it selects an entry on the next edge. The selected entry has the smallest `push_size` among the occupied slots (sizes compared unsigned). Requests pushed after that edge do not displace the selection.
- R3: Ties on size go to the smaller start time (unsigned). Ties on both size and start time go to the lower slot index. Slots are filled lowest free index first, and `grant_slot` reports the slot number.
- R4: `working` is 1 whenever at least one slot is occupied, whether pending or in service, and 0 otherwise.
- R5: If the selected direction equals the last served direction, `grant_valid` rises the cycle after selection and `sw_req` stays low.
- R6: If the directions differ, `sw_req` is held high with `sw_dir` equal to the new direction until an edge with `sw_ack` high, and `grant_valid` stays low during this time. On that edge the served direction takes the new value. Direction encoding is 0 = read (enables `path_in_en`) and 1 = write (enables `path_out_en`). Exactly one enable is high at all times.
- R7: `grant_valid` and its fields stay stable until `grant_ready`. The granted slot stays occupied until `done` arrives while the request is in service. `done` at any other time, and `grant_ready` outside a grant, are ignored.
- R8: After reset, no slot is occupied, `push_ready` is 1, `working` is 0, `grant_valid` and `sw_req` are 0, and the read path is enabled.
- R9: A push and a completion on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | New request offered |
| push_ready | output | 1 | A free slot exists |
| push_dir | input | 1 | Request direction, 0 read, 1 write |
| push_time | input | TIME_W | Request start time |
| push_size | input | SIZE_W | Request size |
| grant_valid | output | 1 | Selected request offered for service |
| grant_ready | input | 1 | Service starts on this edge |
| grant_slot | output | IDX_W | Slot of the granted request |
| grant_dir | output | 1 | Direction of the granted request |
| grant_time | output | TIME_W | Start time of the granted request |
| grant_size | output | SIZE_W | Size of the granted request |
| done | input | 1 | Service of the granted request has finished |
| sw_req | output | 1 | Direction switch requested |
| sw_dir | output | 1 | Direction to switch to |
| sw_ack | input | 1 | Switch finished |
| path_in_en | output | 1 | Receive datapath enabled |
| path_out_en | output | 1 | Transmit datapath enabled |
| working | output | 1 | Work held, for the rate governor |

## Verification
The first pattern fills the queue while grants are stalled, with sizes and start times drawn from a small range. This exposes refused pushes at full occupancy, and checks that the grant order follows size first, then age, then slot index. A second pattern uses equal size and equal start time everywhere, so only the slot index can separate the candidates. Long stretches of mixed-direction traffic then randomise the acknowledge, grant-ready and completion delays. This separates the same-direction path, which has no switch, from the switching path. It also produces pushes on the same edge as a completion, and stray `done` pulses that must be ignored.

// File: rtl/sjf_pkg.sv
package sjf_pkg;
  typedef enum logic [1:0] {
    ST_PICK   = 2'd0,
    ST_SWITCH = 2'd1,
    ST_GRANT  = 2'd2,
    ST_SERVE  = 2'd3
  } disp_state_e;

  localparam logic DIR_READ  = 1'b0;
  localparam logic DIR_WRITE = 1'b1;
endpackage

// File: rtl/sjf_slot_store.sv
module sjf_slot_store #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int SIZE_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_dir,
  input  logic [TIME_W-1:0]              wr_time,
  input  logic [SIZE_W-1:0]              wr_size,
  input  logic                           clr_en,
  input  logic [IDX_W-1:0]               clr_idx,
  output logic [DEPTH-1:0]               occ,
  output logic [DEPTH-1:0]               dir_q,
  output logic [DEPTH-1:0][TIME_W-1:0]   time_q,
  output logic [DEPTH-1:0][SIZE_W-1:0]   size_q,
  output logic                           full
);
  logic [IDX_W-1:0] free_idx;

  // lowest free slot first
  always_comb begin
    free_idx = '0;
    full     = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        free_idx = IDX_W'(i);
        full     = 1'b0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic take, drop;
    assign take = wr_en && (free_idx == IDX_W'(g));
    assign drop = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ[g]    <= 1'b0;
        dir_q[g]  <= 1'b0;
        time_q[g] <= '0;
        size_q[g] <= '0;
      end else if (take) begin
        occ[g]    <= 1'b1;
        dir_q[g]  <= wr_dir;
        time_q[g] <= wr_time;
        size_q[g] <= wr_size;
      end else if (drop) begin
        occ[g]    <= 1'b0;
      end
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  p_push_adds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> $countones(occ) == $past($countones(occ)) + 1);

  p_push_and_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clr_en) |=> $countones(occ) == $past($countones(occ)));

  p_clear_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> occ[clr_idx]);
endmodule

// File: rtl/sjf_min_pick.sv
module sjf_min_pick #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int SIZE_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]               occ,
  input  logic [DEPTH-1:0][TIME_W-1:0]   time_q,
  input  logic [DEPTH-1:0][SIZE_W-1:0]   size_q,
  output logic                           found,
  output logic [IDX_W-1:0]               best_idx
);
  logic [SIZE_W-1:0] best_sz;
  logic [TIME_W-1:0] best_tm;

  // ascending scan with strict compares keeps the lower index on full ties
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_sz  = '0;
    best_tm  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (occ[i]) begin
        if (!found || (size_q[i] < best_sz) ||
            ((size_q[i] == best_sz) && (time_q[i] < best_tm))) begin
          found    = 1'b1;
          best_idx = IDX_W'(i);
          best_sz  = size_q[i];
          best_tm  = time_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/sjf_dir_switch.sv
module sjf_dir_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_active,
  input  logic target,
  input  logic ack,
  output logic last_dir,
  output logic in_en,
  output logic out_en
);
  import sjf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 last_dir <= DIR_READ;
    else if (req_active && ack) last_dir <= target;
  end

  assign in_en  = (last_dir == DIR_READ);
  assign out_en = (last_dir == DIR_WRITE);

  p_ack_commits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active && ack) |=> last_dir == $past(target));

  p_hold_without_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_active && ack) |=> $stable(last_dir));

  p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_en, out_en}) == 1);
endmodule

// File: rtl/sjf_dispatch.sv
module sjf_dispatch #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int SIZE_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic              push_dir,
  input  logic [TIME_W-1:0] push_time,
  input  logic [SIZE_W-1:0] push_size,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [IDX_W-1:0]  grant_slot,
  output logic              grant_dir,
  output logic [TIME_W-1:0] grant_time,
  output logic [SIZE_W-1:0] grant_size,
  input  logic              done,
  output logic              sw_req,
  output logic              sw_dir,
  input  logic              sw_ack,
  output logic              path_in_en,
  output logic              path_out_en,
  output logic              working
);
  import sjf_pkg::*;

  disp_state_e                  state;
  logic [IDX_W-1:0]             sel_idx;
  logic                         cur_dir;
  logic [DEPTH-1:0]             occ;
  logic [DEPTH-1:0]             dir_q;
  logic [DEPTH-1:0][TIME_W-1:0] time_q;
  logic [DEPTH-1:0][SIZE_W-1:0] size_q;
  logic                         full;
  logic                         found;
  logic [IDX_W-1:0]             best_idx;
  logic                         last_dir;
  logic                         wr_en;
  logic                         clr_en;

  assign push_ready = !full;
  assign wr_en      = push_valid && push_ready;
  assign clr_en     = (state == ST_SERVE) && done;

  sjf_slot_store #(.DEPTH(DEPTH), .TIME_W(TIME_W), .SIZE_W(SIZE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_dir  (push_dir),
    .wr_time (push_time),
    .wr_size (push_size),
    .clr_en  (clr_en),
    .clr_idx (sel_idx),
    .occ     (occ),
    .dir_q   (dir_q),
    .time_q  (time_q),
    .size_q  (size_q),
    .full    (full)
  );

  sjf_min_pick #(.DEPTH(DEPTH), .TIME_W(TIME_W), .SIZE_W(SIZE_W)) u_pick (
    .occ      (occ),
    .time_q   (time_q),
    .size_q   (size_q),
    .found    (found),
    .best_idx (best_idx)
  );

  sjf_dir_switch u_switch (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_active (state == ST_SWITCH),
    .target     (cur_dir),
    .ack        (sw_ack),
    .last_dir   (last_dir),
    .in_en      (path_in_en),
    .out_en     (path_out_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_PICK;
      sel_idx <= '0;
      cur_dir <= DIR_READ;
    end else begin
      unique case (state)
        ST_PICK: if (found) begin
          sel_idx <= best_idx;
          cur_dir <= dir_q[best_idx];
          state   <= (dir_q[best_idx] != last_dir) ? ST_SWITCH : ST_GRANT;
        end
        ST_SWITCH: if (sw_ack)      state <= ST_GRANT;
        ST_GRANT:  if (grant_ready) state <= ST_SERVE;
        default:   if (done)        state <= ST_PICK;
      endcase
    end
  end

  assign sw_req      = (state == ST_SWITCH);
  assign sw_dir      = cur_dir;
  assign grant_valid = (state == ST_GRANT);
  assign grant_slot  = sel_idx;
  assign grant_dir   = dir_q[sel_idx];
  assign grant_time  = time_q[sel_idx];
  assign grant_size  = size_q[sel_idx];
  assign working     = |occ;

  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      grant_valid && $stable(grant_slot) && $stable(grant_size) && $stable(grant_time));

  p_sw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !sw_ack) |=> sw_req && $stable(sw_dir));

  p_no_grant_while_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> !grant_valid);

  p_grant_on_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_dir ? path_out_en : path_in_en));

  p_idle_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !working |-> (!grant_valid && !sw_req && push_ready));

  p_granted_slot_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid || state == ST_SERVE) |-> occ[sel_idx]);
endmodule

// File: tb/sjf_dispatch_tb.sv
module sjf_dispatch_tb;
  localparam int DEPTH  = 8;
  localparam int TIME_W = 16;
  localparam int SIZE_W = 12;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic              push_ready;
  logic              push_dir = 1'b0;
  logic [TIME_W-1:0] push_time = '0;
  logic [SIZE_W-1:0] push_size = '0;
  logic              grant_valid;
  logic              grant_ready = 1'b0;
  logic [IDX_W-1:0]  grant_slot;
  logic              grant_dir;
  logic [TIME_W-1:0] grant_time;
  logic [SIZE_W-1:0] grant_size;
  logic              done = 1'b0;
  logic              sw_req;
  logic              sw_dir;
  logic              sw_ack = 1'b0;
  logic              path_in_en;
  logic              path_out_en;
  logic              working;

  always #4 clk = ~clk;

  sjf_dispatch #(.DEPTH(DEPTH), .TIME_W(TIME_W), .SIZE_W(SIZE_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_dir(push_dir),
    .push_time(push_time), .push_size(push_size),
    .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_slot(grant_slot),
    .grant_dir(grant_dir), .grant_time(grant_time), .grant_size(grant_size),
    .done(done), .sw_req(sw_req), .sw_dir(sw_dir), .sw_ack(sw_ack),
    .path_in_en(path_in_en), .path_out_en(path_out_en), .working(working)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference: 0 idle, 1 switching, 2 offering, 3 serving
  bit mv[DEPTH];
  bit md[DEPTH];
  int mt[DEPTH];
  int ms[DEPTH];
  int mst = 0;
  int msel = 0;
  bit mprev = 0;
  bit mcur = 0;
  bit both_last = 0;

  always @(posedge clk) begin : model
    int  fr;
    bit  fl;
    int  bi;
    bit  bf;
    bit  pushed;
    bit  cleared;
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mv[i] = 0;
      mst = 0; msel = 0; mprev = 0; mcur = 0; both_last = 0;
    end else begin
      fl = 1; fr = 0;
      for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) begin fl = 0; fr = i; end
      bf = 0; bi = 0;
      for (int i = 0; i < DEPTH; i++)
        if (mv[i] && (!bf || ms[i] < ms[bi] || (ms[i] == ms[bi] && mt[i] < mt[bi]))) begin
          bf = 1; bi = i;
        end
      cleared = 0;
      case (mst)
        0: if (bf) begin msel = bi; mcur = md[bi]; mst = (md[bi] != mprev) ? 1 : 2; end
        1: if (sw_ack) begin mprev = mcur; mst = 2; end
        2: if (grant_ready) mst = 3;
        default: if (done) begin mv[msel] = 0; mst = 0; cleared = 1; end
      endcase
      pushed = push_valid && !fl;
      if (pushed) begin
        mv[fr] = 1; md[fr] = push_dir; mt[fr] = int'(push_time); ms[fr] = int'(push_size);
      end
      both_last = pushed && cleared;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit full, any;
    full = 1; any = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!mv[i]) full = 0;
      if (mv[i])  any  = 1;
    end
    chk(both_last ? "R9" : "R1", "push_ready", 32'(push_ready), 32'(!full));
    chk(both_last ? "R9" : "R4", "working", 32'(working), 32'(any));
    chk("R6", "sw_req", 32'(sw_req), 32'(mst == 1));
    if (mst == 1) chk("R6", "sw_dir", 32'(sw_dir), 32'(mcur));
    chk("R5", "grant_valid", 32'(grant_valid), 32'(mst == 2));
    if (mst == 2) begin
      chk("R3", "grant_slot", 32'(grant_slot), 32'(msel));
      chk("R2", "grant_size", 32'(grant_size), 32'(ms[msel]));
      chk("R7", "grant_time", 32'(grant_time), 32'(mt[msel]));
      chk("R7", "grant_dir", 32'(grant_dir), 32'(md[msel]));
    end
    chk("R6", "path_in_en", 32'(path_in_en), 32'(!mprev));
    chk("R6", "path_out_en", 32'(path_out_en), 32'(mprev));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    int push_pct, gr_pct, ack_pct, done_pct, sz_max, tm_max;
    for (int c = 0; c < 4200; c++) begin
      @(negedge clk);
      if (!rst_n) begin
        chk("R8", "push_ready", 32'(push_ready), 32'd1);
        chk("R8", "working", 32'(working), 32'd0);
        chk("R8", "grant_valid", 32'(grant_valid), 32'd0);
        chk("R8", "sw_req", 32'(sw_req), 32'd0);
        chk("R8", "path_in_en", 32'(path_in_en), 32'd1);
      end else begin
        compare_all();
      end
      if (c == 4) rst_n = 1'b1;
      // phase knobs
      if (c < 5)         begin push_pct = 0;   gr_pct = 0;  ack_pct = 100; done_pct = 0;  sz_max = 3;  tm_max = 3; end
      else if (c < 40)   begin push_pct = 100; gr_pct = 0;  ack_pct = 100; done_pct = 0;  sz_max = 3;  tm_max = 3; end
      else if (c < 200)  begin push_pct = 0;   gr_pct = 60; ack_pct = 50;  done_pct = 40; sz_max = 3;  tm_max = 3; end
      else if (c < 240)  begin push_pct = 100; gr_pct = 0;  ack_pct = 100; done_pct = 0;  sz_max = 0;  tm_max = 0; end
      else if (c < 400)  begin push_pct = 0;   gr_pct = 70; ack_pct = 60;  done_pct = 50; sz_max = 0;  tm_max = 0; end
      else               begin push_pct = 45;  gr_pct = 70; ack_pct = 50;  done_pct = 35; sz_max = 9;  tm_max = 20; end
      push_valid  = ($urandom_range(0, 99) < push_pct);
      push_dir    = 1'($urandom_range(0, 1));
      push_size   = SIZE_W'($urandom_range(0, sz_max));
      push_time   = TIME_W'($urandom_range(0, tm_max));
      grant_ready = ($urandom_range(0, 99) < gr_pct);
      sw_ack      = ($urandom_range(0, 99) < ack_pct);
      done        = ($urandom_range(0, 99) < done_pct);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule